// File: doc/BRIEF.md
# Bus Controller Frame and Message-Gap Timers

This block keeps time for the sequencer of a MIL-STD-1553 bus controller. It has two independent countdowns. The frame counter reloads from a host-written 16-bit frame length at every frame start and counts one step per 100 µs. It can restart itself at the end of each frame, or stop and hold at zero. It can also act as a watchdog: the sequencer restarts the frame to kick it, and if the frame runs out first, a sticky timeout flag is raised.

The gap counter counts one step per 1 µs. It measures the time left before the next message and serves the sequencer's delay instruction. The sequencer loads it with a count and receives a one-cycle done pulse when the count runs out. Both remaining counts are presented as outputs so the host can read them.

Each counter has its own clock divider. A divider restarts whenever its counter is loaded, so every interval is an exact number of clock cycles. `CLK_PER_US` gives the number of system clocks per microsecond. `US_PER_FTICK` gives the number of microseconds per frame step (100 by default).

Top module: `bc_frame_gap_timer`

## Requirements
- R1: After reset, frame_remaining, gap_remaining, frame_start, dly_done and wdt_timeout are all zero, and the stored frame length is zero.
- R2: A frame_go captured at edge E loads frame_remaining with the stored frame length N and sets frame_start high for the cycle after E. frame_remaining then drops by one at edge E+k·D for k = 1..N, where D = CLK_PER_US·US_PER_FTICK.
- R3: With auto_repeat_en high, the edge at which frame_remaining would reach zero instead reloads N and sets frame_start for one cycle. The frame period is therefore exactly N·D cycles.
- R4: With auto_repeat_en low, frame_remaining reaches zero at the end of the frame and stays there. No frame_start pulse is produced until the next frame_go.
- R5: A write of ft_wr_data (ft_wr_en high) does not change a frame already counting. The new length is used from the next frame start onward.
- R6: A frame that runs out while watchdog_en is high sets wdt_timeout. The flag stays set until it is cleared. A frame that runs out while watchdog_en is low leaves wdt_timeout unchanged.
- R7: wdt_clear clears wdt_timeout at the next edge. If an expiry and wdt_clear arrive in the same cycle, the flag ends up set.
- R8: A frame_go that arrives before the frame runs out restarts the full frame, so no timeout occurs at the original expiry time. A frame_go in the same cycle as an expiry also wins.
- R9: A dly_load with nonzero value V captured at edge L sets gap_remaining to V after L. gap_remaining then drops by one at edge L+k·CLK_PER_US. dly_done is high only in the cycle after the edge where gap_remaining reaches zero.
- R10: A dly_load with value 0 sets gap_remaining to 0 and raises dly_done in the very next cycle, for one cycle.
- R11: A dly_load while the gap counter is running discards the old count and restarts timing from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ft_wr_en | input | 1 | Host write strobe for the frame length |
| ft_wr_data | input | 16 | Frame length in 100 µs steps |
| frame_go | input | 1 | Start or restart (kick) the frame counter |
| auto_repeat_en | input | 1 | Restart the frame automatically at expiry |
| watchdog_en | input | 1 | Treat frame expiry as a sequencer watchdog timeout |
| wdt_clear | input | 1 | Host clear of the timeout flag |
| dly_load | input | 1 | Load the gap/delay counter |
| dly_value | input | 16 | Gap/delay count in 1 µs steps |
| frame_remaining | output | 16 | Frame steps remaining |
| frame_start | output | 1 | One-cycle pulse at each frame start |
| gap_remaining | output | 16 | Microseconds remaining to the next message |
| dly_done | output | 1 | One-cycle pulse when the delay runs out |
| wdt_timeout | output | 1 | Sticky watchdog timeout flag |

## Verification
Two events can collide in one cycle: a watchdog expiry and an action on the flag. The bench drives wdt_clear into exactly the cycle whose edge ends the frame and expects wdt_timeout to read high afterwards. It also kicks the frame with frame_go before the expiry edge and checks that no timeout appears at the old deadline but does appear one full frame after the kick. Every sample is taken against a cycle count since the load edge, so an off-by-one in either divider or in the reload shows up as a miscompare.

// File: rtl/bcft_pkg.sv
package bcft_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] bcft_cnt_t;
endpackage

// File: rtl/bcft_tick_div.sv
// Clock divider: tick is high once every DIV cycles, phase reset by restart.
module bcft_tick_div #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bcft_frame_ctr.sv
// Frame countdown with auto-repeat; reports expiry to the watchdog logic.
module bcft_frame_ctr
  import bcft_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      go,
  input  logic      auto_rep,
  input  bcft_cnt_t reload_val,
  output bcft_cnt_t rem,
  output logic      start_pulse,
  output logic      div_restart,
  output logic      expire_evt
);
  logic running;
  logic expire;

  assign expire      = running && tick && (rem <= bcft_cnt_t'(1));
  assign expire_evt  = expire && !go;
  assign div_restart = go || (expire && auto_rep);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem         <= '0;
      running     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (go) begin
        rem         <= reload_val;
        running     <= 1'b1;
        start_pulse <= 1'b1;
      end else if (expire) begin
        if (auto_rep) begin
          rem         <= reload_val;
          start_pulse <= 1'b1;
        end else begin
          rem     <= '0;
          running <= 1'b0;
        end
      end else if (running && tick) begin
        rem <= rem - bcft_cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/bcft_gap_ctr.sv
// Message-gap / delay countdown with a done pulse.
module bcft_gap_ctr
  import bcft_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  bcft_cnt_t value,
  output bcft_cnt_t rem,
  output logic      done
);
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        rem  <= value;
        busy <= (value != '0);
        done <= (value == '0);
      end else if (busy && tick) begin
        rem <= rem - bcft_cnt_t'(1);
        if (rem == bcft_cnt_t'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bc_frame_gap_timer.sv
module bc_frame_gap_timer
  import bcft_pkg::*;
#(
  parameter int CLK_PER_US   = 100,
  parameter int US_PER_FTICK = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ft_wr_en,
  input  logic [15:0] ft_wr_data,
  input  logic        frame_go,
  input  logic        auto_repeat_en,
  input  logic        watchdog_en,
  input  logic        wdt_clear,
  input  logic        dly_load,
  input  logic [15:0] dly_value,
  output logic [15:0] frame_remaining,
  output logic        frame_start,
  output logic [15:0] gap_remaining,
  output logic        dly_done,
  output logic        wdt_timeout
);
  localparam int FRAME_DIV = CLK_PER_US * US_PER_FTICK;

  bcft_cnt_t frame_len_q;
  logic      ftick, gtick;
  logic      f_restart;
  logic      f_expire;

  always_ff @(posedge clk) begin
    if (rst)           frame_len_q <= '0;
    else if (ft_wr_en) frame_len_q <= ft_wr_data;
  end

  bcft_tick_div #(.DIV(FRAME_DIV)) u_fdiv (
    .clk(clk), .rst(rst), .restart(f_restart), .tick(ftick)
  );

  bcft_tick_div #(.DIV(CLK_PER_US)) u_gdiv (
    .clk(clk), .rst(rst), .restart(dly_load), .tick(gtick)
  );

  bcft_frame_ctr u_frame (
    .clk(clk), .rst(rst), .tick(ftick), .go(frame_go),
    .auto_rep(auto_repeat_en), .reload_val(frame_len_q),
    .rem(frame_remaining), .start_pulse(frame_start),
    .div_restart(f_restart), .expire_evt(f_expire)
  );

  bcft_gap_ctr u_gap (
    .clk(clk), .rst(rst), .tick(gtick), .load(dly_load),
    .value(dly_value), .rem(gap_remaining), .done(dly_done)
  );

  // Sticky watchdog flag: a new expiry outranks a host clear.
  always_ff @(posedge clk) begin
    if (rst)                            wdt_timeout <= 1'b0;
    else if (f_expire && watchdog_en)   wdt_timeout <= 1'b1;
    else if (wdt_clear)                 wdt_timeout <= 1'b0;
  end
endmodule

// File: rtl/bcft_timer_chk.sv
module bcft_timer_chk
  import bcft_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      frame_go,
  input logic      auto_repeat_en,
  input logic      watchdog_en,
  input logic      wdt_clear,
  input logic      dly_load,
  input bcft_cnt_t dly_value,
  input bcft_cnt_t frame_remaining,
  input logic      frame_start,
  input bcft_cnt_t gap_remaining,
  input logic      dly_done,
  input logic      wdt_timeout
);
  // R2
  go_starts_frame_chk: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> frame_start);

  // R2
  frame_step_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_go |=> (frame_start || frame_remaining == $past(frame_remaining) ||
                   frame_remaining == $past(frame_remaining) - bcft_cnt_t'(1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_repeat_en && !frame_go && frame_remaining == '0) |=>
      (frame_remaining == '0 && !frame_start));

  // R6
  wdt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_timeout && !wdt_clear) |=> wdt_timeout);

  // R6
  wdt_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !watchdog_en |=> !$rose(wdt_timeout));

  // R9
  gap_step_chk: assert property (@(posedge clk) disable iff (rst)
    !dly_load |=> (gap_remaining == $past(gap_remaining) ||
                   gap_remaining == $past(gap_remaining) - bcft_cnt_t'(1)));

  // R9
  done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dly_done |-> (gap_remaining == '0));

  // R10
  zero_load_done_chk: assert property (@(posedge clk) disable iff (rst)
    (dly_load && dly_value == '0) |=> dly_done);
endmodule

bind bc_frame_gap_timer bcft_timer_chk u_chk (
  .clk(clk), .rst(rst), .frame_go(frame_go), .auto_repeat_en(auto_repeat_en),
  .watchdog_en(watchdog_en), .wdt_clear(wdt_clear), .dly_load(dly_load),
  .dly_value(dly_value), .frame_remaining(frame_remaining),
  .frame_start(frame_start), .gap_remaining(gap_remaining),
  .dly_done(dly_done), .wdt_timeout(wdt_timeout)
);

// File: tb/test_bc_frame_gap_timer.sv
module test_bc_frame_gap_timer;
  localparam int CPU = 4;
  localparam int UPF = 100;
  localparam int D   = CPU * UPF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ft_wr_en = 1'b0;
  logic [15:0] ft_wr_data = '0;
  logic        frame_go = 1'b0;
  logic        auto_repeat_en = 1'b0;
  logic        watchdog_en = 1'b0;
  logic        wdt_clear = 1'b0;
  logic        dly_load = 1'b0;
  logic [15:0] dly_value = '0;
  logic [15:0] frame_remaining;
  logic        frame_start;
  logic [15:0] gap_remaining;
  logic        dly_done;
  logic        wdt_timeout;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bc_frame_gap_timer #(.CLK_PER_US(CPU), .US_PER_FTICK(UPF)) i_bc_frame_gap_timer (
    .clk(clk), .rst(rst), .ft_wr_en(ft_wr_en), .ft_wr_data(ft_wr_data),
    .frame_go(frame_go), .auto_repeat_en(auto_repeat_en),
    .watchdog_en(watchdog_en), .wdt_clear(wdt_clear),
    .dly_load(dly_load), .dly_value(dly_value),
    .frame_remaining(frame_remaining), .frame_start(frame_start),
    .gap_remaining(gap_remaining), .dly_done(dly_done),
    .wdt_timeout(wdt_timeout)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic write_len(input logic [15:0] v);
    @(negedge clk); ft_wr_en = 1'b1; ft_wr_data = v;
    @(negedge clk); ft_wr_en = 1'b0;
  endtask

  task automatic go(output int t);
    @(negedge clk); frame_go = 1'b1;
    @(negedge clk); frame_go = 1'b0; t = cyc;
  endtask

  task automatic load_gap(input logic [15:0] v, output int t);
    @(negedge clk); dly_load = 1'b1; dly_value = v;
    @(negedge clk); dly_load = 1'b0; t = cyc;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "frame_remaining", frame_remaining, 0);
    chk("R1", "gap_remaining", gap_remaining, 0);
    chk("R1", "frame_start", frame_start, 0);
    chk("R1", "dly_done", dly_done, 0);
    chk("R1", "wdt_timeout", wdt_timeout, 0);
  endtask

  task automatic t_single_frame();
    int t0;
    auto_repeat_en = 1'b0;
    write_len(16'd3);
    go(t0);
    chk("R2", "frame_start at go", frame_start, 1);
    chk("R2", "loaded length", frame_remaining, 3);
    wait_until(t0 + 1);
    chk("R2", "frame_start one cycle", frame_start, 0);
    wait_until(t0 + D - 1);
    chk("R2", "before first step", frame_remaining, 3);
    wait_until(t0 + D);
    chk("R2", "first step", frame_remaining, 2);
    wait_until(t0 + 3 * D);
    chk("R4", "reaches zero", frame_remaining, 0);
    chk("R4", "no restart pulse", frame_start, 0);
    wait_until(t0 + 3 * D + 500);
    chk("R4", "holds zero", frame_remaining, 0);
  endtask

  task automatic t_auto_repeat();
    int t0;
    auto_repeat_en = 1'b1;
    write_len(16'd2);
    go(t0);
    wait_until(t0 + 2 * D - 1);
    chk("R3", "last step of frame", frame_remaining, 1);
    chk("R3", "no early pulse", frame_start, 0);
    wait_until(t0 + 2 * D);
    chk("R3", "auto pulse", frame_start, 1);
    chk("R3", "auto reload", frame_remaining, 2);
    write_len(16'd5);
    wait_until(t0 + 3 * D);
    chk("R5", "running frame unaffected", frame_remaining, 1);
    wait_until(t0 + 4 * D);
    chk("R5", "new length at next start", frame_remaining, 5);
    chk("R3", "second auto pulse", frame_start, 1);
    @(negedge clk); auto_repeat_en = 1'b0;
    wait_until(t0 + 9 * D);
    chk("R4", "stops after auto off", frame_remaining, 0);
    chk("R4", "no pulse after auto off", frame_start, 0);
  endtask

  task automatic t_watchdog();
    int t0, t1, t2, t3;
    auto_repeat_en = 1'b0;
    watchdog_en = 1'b1;
    write_len(16'd1);
    go(t0);
    wait_until(t0 + 300);
    go(t1);
    wait_until(t0 + D);
    chk("R8", "kick prevents old deadline", wdt_timeout, 0);
    wait_until(t1 + D - 1);
    chk("R8", "no timeout before new deadline", wdt_timeout, 0);
    wait_until(t1 + D);
    chk("R6", "timeout set", wdt_timeout, 1);
    wait_until(t1 + D + 50);
    chk("R6", "timeout sticky", wdt_timeout, 1);
    @(negedge clk); wdt_clear = 1'b1;
    @(negedge clk); wdt_clear = 1'b0;
    chk("R7", "clear", wdt_timeout, 0);
    go(t2);
    wait_until(t2 + D - 1);
    chk("R7", "clean before collision", wdt_timeout, 0);
    wdt_clear = 1'b1;
    wait_until(t2 + D);
    chk("R7", "expiry beats clear", wdt_timeout, 1);
    wdt_clear = 1'b0;
    @(negedge clk); wdt_clear = 1'b1;
    @(negedge clk); wdt_clear = 1'b0;
    chk("R7", "clear after collision", wdt_timeout, 0);
    watchdog_en = 1'b0;
    go(t3);
    wait_until(t3 + D + 5);
    chk("R6", "no flag with watchdog off", wdt_timeout, 0);
    chk("R6", "frame still ends", frame_remaining, 0);
  endtask

  task automatic t_gap();
    int l1, l2, l3;
    load_gap(16'd5, l1);
    chk("R9", "loaded", gap_remaining, 5);
    chk("R9", "no done at load", dly_done, 0);
    wait_until(l1 + CPU - 1);
    chk("R9", "before first step", gap_remaining, 5);
    wait_until(l1 + CPU);
    chk("R9", "first step", gap_remaining, 4);
    wait_until(l1 + 5 * CPU - 1);
    chk("R9", "last count", gap_remaining, 1);
    chk("R9", "done not early", dly_done, 0);
    wait_until(l1 + 5 * CPU);
    chk("R9", "zero", gap_remaining, 0);
    chk("R9", "done pulse", dly_done, 1);
    wait_until(l1 + 5 * CPU + 1);
    chk("R9", "done one cycle", dly_done, 0);
    load_gap(16'd10, l2);
    wait_until(l2 + 6);
    chk("R11", "old count running", gap_remaining, 9);
    load_gap(16'd3, l3);
    chk("R11", "reloaded", gap_remaining, 3);
    wait_until(l3 + CPU - 1);
    chk("R11", "new phase", gap_remaining, 3);
    wait_until(l3 + 3 * CPU);
    chk("R11", "reloaded done", dly_done, 1);
  endtask

  task automatic t_zero_delay();
    int l0;
    load_gap(16'd0, l0);
    chk("R10", "immediate done", dly_done, 1);
    chk("R10", "remaining zero", gap_remaining, 0);
    wait_until(l0 + 1);
    chk("R10", "done one cycle", dly_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single_frame();
    t_auto_repeat();
    t_watchdog();
    t_gap();
    t_zero_delay();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule